// File: doc/BRIEF.md
# MSI Snooping Cache-Line Controller

This block is the coherence controller that sits beside one processor's small direct-mapped write-back cache on a shared, atomic snooping bus. Each cache line holds a single data word and a three-state tag: Invalid, Shared or Modified. The controller accepts one processor read or write at a time and holds it until it completes. Hits that need no bus traffic complete locally. Every other access becomes a bus transaction that waits for the arbiter's grant.

The bus side has two faces. A request port raises a read, read-for-ownership, upgrade or write-back toward an external arbiter and holds it until it is granted. A snoop port sees every granted transaction on the bus. The controller reacts to foreign transactions that hit its lines. When it owns a dirty copy that another cache reads, it drives that copy onto the flush path; memory then takes the word and abandons its own reply. Because a write completes only when its transaction wins the bus, the order of grants on the bus is the global order of writes.

Several controllers share one bus. Each is told its own requester number, so that it can recognise and ignore its own traffic on the snoop port.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and the block raises no bus request, no processor acknowledge and no flush.
- R2: A read to a line that is not held issues a read transaction (bus_op code 1) and leaves the line Shared. A write to a line that is not held issues a read-for-ownership (code 2) and leaves the line Modified.
- R3: A read hitting a Shared or Modified line, and a write hitting a Modified line, complete with no bus transaction.
- R4: A write hitting a Shared line issues an upgrade (code 3) with no data refetch, and the line becomes Modified.
- R5: A foreign read (code 1) that hits a Modified line raises flush_valid with the line's word in the same cycle, and the line becomes Shared.
- R6: A foreign read-for-ownership (code 2) that hits a Modified line flushes the word in the same cycle, and the line becomes Invalid.
- R7: A foreign read to a Shared line changes nothing. A foreign read-for-ownership or upgrade to a Shared line invalidates it with no flush. Foreign transactions that miss, or that find the line Invalid, are ignored.
- R8: On a miss, a Shared victim with a different tag is dropped silently. A Modified victim is first written back with a write-back transaction (code 4) carrying its word, and only then is the new line requested.
- R9: An access that needs the bus completes only in the cycle after its grant. cpu_ack is a single-cycle pulse, and cpu_rdata is valid with it: the read word, or the written word for a write.
- R10: If a foreign read-for-ownership or upgrade invalidates the line of a pending upgrade before that upgrade is granted, the pending request becomes a read-for-ownership.
- R11: An ungranted bus request keeps its request, code and address unchanged unless a snooped transaction arrives in the same cycle. The block's own transaction, identified by snp_id equal to MY_ID, has no effect on its lines.
- R12: Across controllers that share the bus, a read that follows a completed write to the same address returns the written word. Hence at most one cache holds a line Modified, and no other cache then holds it Shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until cpu_ack |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Result word, valid with cpu_ack |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_op | output | 3 | Requested transaction: 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back |
| bus_addr | output | ADDR_W | Address of the requested transaction |
| bus_data | output | DATA_W | Word carried by a write-back |
| bus_gnt | input | 1 | Grant; the transaction takes place in this cycle |
| snp_valid | input | 1 | A granted transaction is on the bus |
| snp_op | input | 3 | Code of the transaction on the bus |
| snp_addr | input | ADDR_W | Address of the transaction on the bus |
| snp_id | input | ID_W | Requester number of the transaction on the bus |
| fill_data | input | DATA_W | Word returned for a granted read or read-for-ownership |
| flush_valid | output | 1 | This cache supplies the word; memory updates and cancels its read |
| flush_data | output | DATA_W | Flushed word |

## Verification
On every cycle the bound checker confirms that a request holds steady until grant when no snoop intervenes. It also confirms that flushes appear only for foreign reads or reads-for-ownership, that an upgrade never causes a flush, and that the acknowledge is a single pulse after which the request drops. The state sequences themselves can be seen only through the bench's scenarios. With three controllers and a memory model, the bench checks which transaction each access issues, which cache flushes and which word comes back. It covers the silent and dirty replacement paths, a grant held back by the arbiter, and two simultaneous upgrades where the loser has to turn into a read-for-ownership.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_M = 2'd2
    } line_st_e;

    typedef enum logic [2:0] {
        BOP_NONE = 3'd0,
        BOP_RD   = 3'd1,
        BOP_RDX  = 3'd2,
        BOP_UPG  = 3'd3,
        BOP_WB   = 3'd4
    } bus_op_e;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_WB   = 2'd1,
        CS_REQ  = 2'd2,
        CS_DONE = 2'd3
    } ctrl_st_e;

endpackage

// File: rtl/msi_snoop_resp.sv
module msi_snoop_resp
    import msi_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              snp_valid,
    input  logic              snp_foreign,
    input  bus_op_e           snp_op,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_e          line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              hit,
    output line_st_e          next_st,
    output logic              flush_valid,
    output logic [DATA_W-1:0] flush_data
);

    always_comb begin
        hit         = snp_valid && snp_foreign && (line_st != LS_I) && (line_tag == snp_tag);
        next_st     = line_st;
        flush_valid = 1'b0;
        if (hit) begin
            unique case (snp_op)
                BOP_RD: begin
                    if (line_st == LS_M) begin
                        flush_valid = 1'b1;
                        next_st     = LS_S;
                    end
                end
                BOP_RDX: begin
                    flush_valid = (line_st == LS_M);
                    next_st     = LS_I;
                end
                BOP_UPG: begin
                    next_st = LS_I;
                end
                default: begin
                    next_st = line_st;
                end
            endcase
        end
    end

    assign flush_data = line_data;

endmodule

// File: rtl/msi_cpu_decode.sv
module msi_cpu_decode
    import msi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             cpu_we,
    input  logic [TAG_W-1:0] req_tag,
    input  line_st_e         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             local_hit,
    output bus_op_e          miss_op,
    output logic             victim_dirty
);

    logic tag_match;

    always_comb begin
        tag_match    = (line_st != LS_I) && (line_tag == req_tag);
        local_hit    = 1'b0;
        miss_op      = BOP_NONE;
        victim_dirty = 1'b0;
        if (tag_match) begin
            if (!cpu_we || line_st == LS_M) begin
                local_hit = 1'b1;
            end else begin
                miss_op = BOP_UPG;
            end
        end else begin
            miss_op      = cpu_we ? BOP_RDX : BOP_RD;
            victim_dirty = (line_st == LS_M);
        end
    end

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int INDEX_W = 2,
    parameter int ID_W    = 2,
    parameter int MY_ID   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [2:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_gnt,
    input  logic              snp_valid,
    input  logic [2:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id,
    input  logic [DATA_W-1:0] fill_data,
    output logic              flush_valid,
    output logic [DATA_W-1:0] flush_data
);

    localparam int LINES = 1 << INDEX_W;
    localparam int TAG_W = ADDR_W - INDEX_W;

    typedef struct packed {
        ctrl_st_e          fsm;
        bus_op_e           pend_op;
        logic [ADDR_W-1:0] pend_addr;
        logic [DATA_W-1:0] pend_wdata;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    line_st_e          st_d  [LINES];
    line_st_e          st_q  [LINES];
    logic [TAG_W-1:0]  tag_d [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_d [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    // Address slicing
    logic [INDEX_W-1:0] snp_idx, cpu_idx, pend_idx;
    logic [TAG_W-1:0]   snp_tag, cpu_tag, pend_tag;

    assign snp_idx  = snp_addr[INDEX_W-1:0];
    assign snp_tag  = snp_addr[ADDR_W-1:INDEX_W];
    assign cpu_idx  = cpu_addr[INDEX_W-1:0];
    assign cpu_tag  = cpu_addr[ADDR_W-1:INDEX_W];
    assign pend_idx = ctl_q.pend_addr[INDEX_W-1:0];
    assign pend_tag = ctl_q.pend_addr[ADDR_W-1:INDEX_W];

    // Snoop side
    logic     snp_foreign, snp_hit;
    line_st_e snp_next_st;
    bus_op_e  snp_op_e;

    assign snp_foreign = (snp_id != ID_W'(MY_ID));
    assign snp_op_e    = bus_op_e'(snp_op);

    msi_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid   (snp_valid),
        .snp_foreign (snp_foreign),
        .snp_op      (snp_op_e),
        .snp_tag     (snp_tag),
        .line_st     (st_q[snp_idx]),
        .line_tag    (tag_q[snp_idx]),
        .line_data   (dat_q[snp_idx]),
        .hit         (snp_hit),
        .next_st     (snp_next_st),
        .flush_valid (flush_valid),
        .flush_data  (flush_data)
    );

    // Processor side
    logic    dec_local, dec_dirty;
    bus_op_e dec_op;

    msi_cpu_decode #(.TAG_W(TAG_W)) u_decode (
        .cpu_we       (cpu_we),
        .req_tag      (cpu_tag),
        .line_st      (st_q[cpu_idx]),
        .line_tag     (tag_q[cpu_idx]),
        .local_hit    (dec_local),
        .miss_op      (dec_op),
        .victim_dirty (dec_dirty)
    );

    logic victim_still_dirty;
    assign victim_still_dirty = (st_q[pend_idx] == LS_M);

    // Next-state logic
    always_comb begin
        ctl_d     = ctl_q;
        st_d      = st_q;
        tag_d     = tag_q;
        dat_d     = dat_q;
        ctl_d.ack = 1'b0;

        if (snp_hit) begin
            st_d[snp_idx] = snp_next_st;
        end

        unique case (ctl_q.fsm)
            CS_IDLE: begin
                // a snoop touching the same line this cycle defers the decode
                if (cpu_req && !(snp_hit && snp_idx == cpu_idx)) begin
                    ctl_d.pend_addr  = cpu_addr;
                    ctl_d.pend_wdata = cpu_wdata;
                    if (dec_local) begin
                        if (cpu_we) begin
                            dat_d[cpu_idx] = cpu_wdata;
                            ctl_d.rdata    = cpu_wdata;
                        end else begin
                            ctl_d.rdata = dat_q[cpu_idx];
                        end
                        ctl_d.ack = 1'b1;
                        ctl_d.fsm = CS_DONE;
                    end else begin
                        ctl_d.pend_op = dec_op;
                        if (dec_dirty) begin
                            ctl_d.fsm = CS_WB;
                        end else begin
                            if (dec_op != BOP_UPG) begin
                                st_d[cpu_idx] = LS_I;
                            end
                            ctl_d.fsm = CS_REQ;
                        end
                    end
                end
            end
            CS_WB: begin
                if (!victim_still_dirty) begin
                    st_d[pend_idx] = LS_I;
                    ctl_d.fsm      = CS_REQ;
                end else if (bus_gnt) begin
                    st_d[pend_idx] = LS_I;
                    ctl_d.fsm      = CS_REQ;
                end
            end
            CS_REQ: begin
                if (ctl_q.pend_op == BOP_UPG && snp_hit && snp_idx == pend_idx &&
                    (snp_op_e == BOP_RDX || snp_op_e == BOP_UPG)) begin
                    ctl_d.pend_op = BOP_RDX;
                end
                if (bus_gnt) begin
                    tag_d[pend_idx] = pend_tag;
                    ctl_d.ack       = 1'b1;
                    ctl_d.fsm       = CS_DONE;
                    if (ctl_q.pend_op == BOP_RD) begin
                        st_d[pend_idx]  = LS_S;
                        dat_d[pend_idx] = fill_data;
                        ctl_d.rdata     = fill_data;
                    end else begin
                        st_d[pend_idx]  = LS_M;
                        dat_d[pend_idx] = ctl_q.pend_wdata;
                        ctl_d.rdata     = ctl_q.pend_wdata;
                    end
                end
            end
            CS_DONE: begin
                ctl_d.fsm = CS_IDLE;
            end
            default: begin
                ctl_d.fsm = CS_IDLE;
            end
        endcase
    end

    // Registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{fsm: CS_IDLE, pend_op: BOP_NONE, pend_addr: '0,
                       pend_wdata: '0, ack: 1'b0, rdata: '0};
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= LS_I;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else begin
            ctl_q <= ctl_d;
            st_q  <= st_d;
            tag_q <= tag_d;
            dat_q <= dat_d;
        end
    end

    // Outputs
    assign cpu_ack   = ctl_q.ack;
    assign cpu_rdata = ctl_q.rdata;

    always_comb begin
        bus_req  = 1'b0;
        bus_op   = BOP_NONE;
        bus_addr = ctl_q.pend_addr;
        bus_data = dat_q[pend_idx];
        if (ctl_q.fsm == CS_WB && victim_still_dirty) begin
            bus_req  = 1'b1;
            bus_op   = BOP_WB;
            bus_addr = {tag_q[pend_idx], pend_idx};
        end else if (ctl_q.fsm == CS_REQ) begin
            bus_req = 1'b1;
            bus_op  = ctl_q.pend_op;
        end
    end

endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ack,
    input logic              bus_req,
    input logic [2:0]        bus_op,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_gnt,
    input logic              snp_valid,
    input logic [2:0]        snp_op,
    input logic [ID_W-1:0]   snp_id,
    input logic              flush_valid
);

    // R9: completion is a single pulse
    p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R9: a granted access (other than a write-back) completes, so the request drops
    p_gnt_drops_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && bus_op != 3'd4) |=> !bus_req);

    // R11: request held steady until grant when no snoop intervenes
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=> (bus_req && $stable(bus_op) && $stable(bus_addr)));

    // R11: a raised request always carries a real transaction code
    p_req_op_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_op >= 3'd1 && bus_op <= 3'd4));

    // R5 / R6: a flush answers only a foreign read or read-for-ownership
    p_flush_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (snp_valid && snp_id != ID_W'(MY_ID) && (snp_op == 3'd1 || snp_op == 3'd2)));

    // R7: an upgrade never draws a flush
    p_upg_no_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_op == 3'd3) |-> !flush_valid);

endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W),
    .MY_ID  (MY_ID)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_ack     (cpu_ack),
    .bus_req     (bus_req),
    .bus_op      (bus_op),
    .bus_addr    (bus_addr),
    .bus_gnt     (bus_gnt),
    .snp_valid   (snp_valid),
    .snp_op      (snp_op),
    .snp_id      (snp_id),
    .flush_valid (flush_valid)
);

// File: tb/test_msi_line_ctrl.sv
module test_msi_line_ctrl;

    localparam int CLK_P  = 10;
    localparam int NC     = 3;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic [NC-1:0]     cpu_req = '0;
    logic [NC-1:0]     cpu_we  = '0;
    logic [ADDR_W-1:0] cpu_addr  [NC];
    logic [DATA_W-1:0] cpu_wdata [NC];
    logic [NC-1:0]     cpu_ack;
    logic [DATA_W-1:0] cpu_rdata [NC];
    logic [NC-1:0]     bus_req, gnt, flush;
    logic [2:0]        bus_op   [NC];
    logic [ADDR_W-1:0] bus_addr [NC];
    logic [DATA_W-1:0] bus_data [NC];
    logic [DATA_W-1:0] flush_data [NC];

    logic              arb_hold = 1'b0;
    logic              snp_valid;
    logic [2:0]        snp_op;
    logic [ADDR_W-1:0] snp_addr;
    logic [1:0]        snp_id;
    logic [DATA_W-1:0] fill_data;
    logic [DATA_W-1:0] mem [1 << ADDR_W];

    int checks = 0;
    int errors = 0;
    logic [2:0] first_op [NC];
    logic [1:0] flusher;

    // Fixed-priority arbiter and broadcast bus
    always_comb begin
        gnt = '0;
        if (!arb_hold) begin
            if (bus_req[0])      gnt[0] = 1'b1;
            else if (bus_req[1]) gnt[1] = 1'b1;
            else if (bus_req[2]) gnt[2] = 1'b1;
        end
        snp_valid = |gnt;
        snp_id    = gnt[1] ? 2'd1 : (gnt[2] ? 2'd2 : 2'd0);
        snp_op    = snp_valid ? bus_op[snp_id] : 3'd0;
        snp_addr  = bus_addr[snp_id];
        fill_data = mem[snp_addr];
        for (int k = 0; k < NC; k++) begin
            if (flush[k]) fill_data = flush_data[k];
        end
    end

    // Memory model: write-back and flush update it
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < (1 << ADDR_W); a++) mem[a] <= DATA_W'(16'h1000 + a);
        end else if (snp_valid) begin
            if (snp_op == 3'd4) mem[snp_addr] <= bus_data[snp_id];
            for (int k = 0; k < NC; k++) begin
                if (flush[k]) mem[snp_addr] <= flush_data[k];
            end
        end
    end

    for (genvar g = 0; g < NC; g++) begin : g_cache
        msi_line_ctrl #(.MY_ID(g)) i_msi_line_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .cpu_req     (cpu_req[g]),
            .cpu_we      (cpu_we[g]),
            .cpu_addr    (cpu_addr[g]),
            .cpu_wdata   (cpu_wdata[g]),
            .cpu_ack     (cpu_ack[g]),
            .cpu_rdata   (cpu_rdata[g]),
            .bus_req     (bus_req[g]),
            .bus_op      (bus_op[g]),
            .bus_addr    (bus_addr[g]),
            .bus_data    (bus_data[g]),
            .bus_gnt     (gnt[g]),
            .snp_valid   (snp_valid),
            .snp_op      (snp_op),
            .snp_addr    (snp_addr),
            .snp_id      (snp_id),
            .fill_data   (fill_data),
            .flush_valid (flush[g]),
            .flush_data  (flush_data[g])
        );
    end

    // Bus monitor, sampled between edges
    always @(negedge clk) begin
        #2;
        for (int k = 0; k < NC; k++) begin
            if (gnt[k] && first_op[k] == 3'd0) first_op[k] = bus_op[k];
            if (flush[k]) flusher = 2'(k);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input int c, input bit we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, output logic [DATA_W-1:0] rd);
        @(negedge clk);
        first_op[c]  = 3'd0;
        flusher      = 2'd3;
        cpu_we[c]    = we;
        cpu_addr[c]  = a;
        cpu_wdata[c] = wd;
        cpu_req[c]   = 1'b1;
        rd = '0;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (cpu_ack[c]) begin
                rd = cpu_rdata[c];
                break;
            end
        end
        cpu_req[c] = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  cpu;
        logic        we;
        logic [7:0]  addr;
        logic [15:0] wdata;
        logic [2:0]  exp_op;   // first granted op, 0 = none
        logic [1:0]  exp_fl;   // flushing cache, 3 = none
        logic [15:0] exp_rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 8'h10, 16'h0000, 3'd1, 2'd3, 16'h1010, 4'd2},  // R2 read miss
        '{2'd0, 1'b0, 8'h10, 16'h0000, 3'd0, 2'd3, 16'h1010, 4'd3},  // R3 hit in S
        '{2'd1, 1'b0, 8'h10, 16'h0000, 3'd1, 2'd3, 16'h1010, 4'd2},
        '{2'd0, 1'b1, 8'h10, 16'hAAAA, 3'd3, 2'd3, 16'hAAAA, 4'd4},  // R4 upgrade
        '{2'd0, 1'b1, 8'h10, 16'hBBBB, 3'd0, 2'd3, 16'hBBBB, 4'd11}, // R11 own upgrade ignored
        '{2'd0, 1'b0, 8'h10, 16'h0000, 3'd0, 2'd3, 16'hBBBB, 4'd3},
        '{2'd1, 1'b0, 8'h10, 16'h0000, 3'd1, 2'd0, 16'hBBBB, 4'd5},  // R5 flush, R7 was invalidated
        '{2'd0, 1'b0, 8'h10, 16'h0000, 3'd0, 2'd3, 16'hBBBB, 4'd5},  // still S
        '{2'd2, 1'b1, 8'h10, 16'hCCCC, 3'd2, 2'd3, 16'hCCCC, 4'd2},  // R7 S copies dropped, no flush
        '{2'd0, 1'b0, 8'h10, 16'h0000, 3'd1, 2'd2, 16'hCCCC, 4'd7},
        '{2'd1, 1'b1, 8'h10, 16'hDDDD, 3'd2, 2'd3, 16'hDDDD, 4'd7},
        '{2'd2, 1'b1, 8'h10, 16'hEEEE, 3'd2, 2'd1, 16'hEEEE, 4'd6},  // R6 flush on RdX
        '{2'd1, 1'b0, 8'h10, 16'h0000, 3'd1, 2'd2, 16'hEEEE, 4'd12}, // R12
        '{2'd2, 1'b0, 8'h20, 16'h0000, 3'd1, 2'd3, 16'h1020, 4'd8},  // R8 silent drop
        '{2'd2, 1'b1, 8'h20, 16'h1234, 3'd3, 2'd3, 16'h1234, 4'd4},
        '{2'd2, 1'b0, 8'h10, 16'h0000, 3'd4, 2'd3, 16'hEEEE, 4'd8},  // R8 dirty victim
        '{2'd0, 1'b0, 8'h20, 16'h0000, 3'd1, 2'd3, 16'h1234, 4'd8},
        '{2'd0, 1'b1, 8'h11, 16'h4321, 3'd2, 2'd3, 16'h4321, 4'd2},
        '{2'd1, 1'b1, 8'h05, 16'h0555, 3'd2, 2'd3, 16'h0555, 4'd2},
        '{2'd0, 1'b0, 8'h05, 16'h0000, 3'd4, 2'd1, 16'h0555, 4'd8},
        '{2'd2, 1'b0, 8'h11, 16'h0000, 3'd1, 2'd3, 16'h4321, 4'd8},
        '{2'd1, 1'b0, 8'h05, 16'h0000, 3'd0, 2'd3, 16'h0555, 4'd5}
    };

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] rd, rd2;
        for (int k = 0; k < NC; k++) begin
            cpu_addr[k] = '0; cpu_wdata[k] = '0; first_op[k] = 3'd0;
        end
        flusher = 2'd3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: quiet after reset
        check(cpu_ack == '0, "R1", "ack after reset", int'(cpu_ack), 0);
        check(bus_req == '0, "R1", "bus_req after reset", int'(bus_req), 0);
        check(flush == '0, "R1", "flush after reset", int'(flush), 0);

        for (int v = 0; v < NV; v++) begin
            run_op(int'(VECS[v].cpu), VECS[v].we, VECS[v].addr, VECS[v].wdata, rd);
            check(first_op[VECS[v].cpu] == VECS[v].exp_op, $sformatf("R%0d vec%0d", VECS[v].req, v),
                  "bus op", int'(first_op[VECS[v].cpu]), int'(VECS[v].exp_op));
            check(flusher == VECS[v].exp_fl, $sformatf("R%0d vec%0d", VECS[v].req, v),
                  "flusher", int'(flusher), int'(VECS[v].exp_fl));
            check(rd == VECS[v].exp_rd, $sformatf("R%0d vec%0d", VECS[v].req, v),
                  "rdata", int'(rd), int'(VECS[v].exp_rd));
        end

        // R9 / R11: withheld grant, write stays pending and request stays put
        @(negedge clk);
        arb_hold     = 1'b1;
        cpu_we[0]    = 1'b1;
        cpu_addr[0]  = 8'h44;
        cpu_wdata[0] = 16'h7777;
        cpu_req[0]   = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(cpu_ack[0] == 1'b0, "R9", "ack before grant", int'(cpu_ack[0]), 0);
            if (i >= 1) begin
                check(bus_req[0] && bus_op[0] == 3'd2 && bus_addr[0] == 8'h44, "R11",
                      "held request op", int'(bus_op[0]), 2);
            end
        end
        arb_hold = 1'b0;
        rd = '0;
        for (int t = 0; t < 50; t++) begin
            @(negedge clk);
            if (cpu_ack[0]) begin rd = cpu_rdata[0]; break; end
        end
        cpu_req[0] = 1'b0;
        check(rd == 16'h7777, "R9", "write completes after grant", int'(rd), 16'h7777);
        run_op(1, 1'b0, 8'h44, 16'h0, rd);
        check(rd == 16'h7777 && flusher == 2'd0, "R12", "read after held write", int'(rd), 16'h7777);

        // R10: two simultaneous upgrades of a shared line
        run_op(0, 1'b0, 8'h33, 16'h0, rd);
        run_op(1, 1'b0, 8'h33, 16'h0, rd);
        fork
            run_op(0, 1'b1, 8'h33, 16'h0A0A, rd);
            run_op(1, 1'b1, 8'h33, 16'h0B0B, rd2);
        join
        check(first_op[0] == 3'd3, "R10", "winner op", int'(first_op[0]), 3);
        check(first_op[1] == 3'd2, "R10", "loser converted op", int'(first_op[1]), 2);
        check(rd2 == 16'h0B0B, "R10", "loser write data", int'(rd2), 16'h0B0B);
        run_op(2, 1'b0, 8'h33, 16'h0, rd);
        check(rd == 16'h0B0B, "R12", "read sees last bus-ordered write", int'(rd), 16'h0B0B);
        check(flusher == 2'd1, "R6", "loser owns line and flushes", int'(flusher), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule